// File: doc/BRIEF.md
# Region Write-Protected RAM

A synchronous byte-wide RAM whose address range is split into equal regions. Each region is guarded by one bit of a write mask register. A set bit silently discards every write aimed at its region, and a clear bit lets writes through. Reads are never restricted. A privilege input, driven from the processor's interrupt-enable flag, is the only thing that permits updates to the mask. Code running outside interrupt context therefore cannot lift the protection that a scheduler has placed over memory it does not own.

The bus is one address, a write strobe with a data byte, and a read strobe whose data is registered. The address is one bit wider than the array. When that top bit is set, the access goes to the mask register window instead of the array, and the mask can be read back a byte at a time. Two sizes are supported: 1 KB with 16 regions and 4 KB with 32 regions. A parameter can remove protection entirely, which turns the block into plain memory.

Top module: `guarded_sram`

## Requirements
- R1: After reset every mask bit is 0, so all regions accept writes, and `rd_data` reads 0 until the first read.
- R2: With `MEM_AW`=10 (1 KB) there are 16 regions of 64 bytes. The region index is address bits [9:6]. A write to region n is dropped when mask bit n is 1.
- R3: With `MEM_AW`=12 (4 KB) there are 32 regions of 128 bytes. The region index is address bits [11:7]. Mask bit n guards region n.
- R4: A dropped write leaves the stored byte unchanged, and a later read of that address returns the old value.
- R5: An access with address bit `MEM_AW` set targets the mask window. Mask byte k is selected by the low address bits (1 bit for 16 regions, 2 bits for 32 regions; the other window bits are ignored). Byte k holds mask bits 8k to 8k+7, with bit 0 of the byte being region 8k. Reads of the window return these bytes.
- R6: A write to the mask window changes the mask only when `irq_priv` is 1. With `irq_priv` at 0, the mask is left as it was.
- R7: Reads are never blocked. `rd_data` carries the addressed byte from the clock edge where `rd_en` is sampled high. It keeps that value while `rd_en` stays low.
- R8: A mask update takes effect at the clock edge that samples it. A RAM write issued in the very next cycle is judged against the new mask. A RAM write in the same cycle as a mask update is judged against the mask held before that cycle.
- R9: With `PROTECT`=0 every array write is stored whatever was written to the mask window, and mask window reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | MEM_AW+1 | Byte address; top bit selects the mask window |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read byte |
| irq_priv | input | 1 | High while the interrupt flag is set; enables mask updates |

## Verification
A mask write or an array write is sampled at the rising edge where its strobe is high. A read strobe puts its byte on `rd_data` at the next rising edge, one cycle later. The bench drives every input at the falling edge and samples `rd_data` at the falling edge after the strobe, half a cycle after the registers update. For R8 the bench issues a mask write and an array write on consecutive cycles with no idle cycle between them, so the array write meets the mask one edge after it changed. The hold check for R7 reads `rd_data` again over several idle cycles while the address keeps changing.

// File: rtl/gsram_pkg.sv
package gsram_pkg;
   localparam int BYTE_W = 8;

   // number of region-index bits for a supported array size
   function automatic int region_bits(input int aw);
      return (aw == 12) ? 5 : 4;
   endfunction
endpackage

// File: rtl/gsram_decode.sv
module gsram_decode
   import gsram_pkg::*;
#(
   parameter int MEM_AW = 10,
   parameter int RGN_W  = 4,
   parameter int SEL_W  = 1
) (
   input  logic [MEM_AW:0]     addr,
   output logic                win,
   output logic [MEM_AW-1:0]   word,
   output logic [RGN_W-1:0]    region,
   output logic [SEL_W-1:0]    byte_sel
);
   assign win      = addr[MEM_AW];
   assign word     = addr[MEM_AW-1:0];
   assign region   = addr[MEM_AW-1 -: RGN_W];
   assign byte_sel = addr[SEL_W-1:0];
endmodule

// File: rtl/gsram_gate.sv
module gsram_gate #(
   parameter bit PROTECT = 1'b0
) (
   input  logic wr_en,
   input  logic win,
   input  logic priv,
   input  logic blocked_bit,
   output logic ram_we,
   output logic mask_we
);
   generate
      if (PROTECT) begin : g_guarded
         assign ram_we  = wr_en & ~win & ~blocked_bit;
         assign mask_we = wr_en &  win & priv;
      end else begin : g_open
         logic unused_gate;
         assign unused_gate = priv ^ blocked_bit;
         assign ram_we  = wr_en & ~win;
         assign mask_we = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/gsram_mask.sv
module gsram_mask
   import gsram_pkg::*;
#(
   parameter bit PROTECT = 1'b0,
   parameter int NRGN    = 16,
   parameter int SEL_W   = 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                mask_we,
   input  logic                rd_en,
   input  logic [SEL_W-1:0]    byte_sel,
   input  logic [BYTE_W-1:0]   wr_data,
   output logic [NRGN-1:0]     mask,
   output logic [BYTE_W-1:0]   rd_byte
);
   generate
      if (PROTECT) begin : g_reg
         logic [NRGN-1:0]   mask_q;
         logic [BYTE_W-1:0] rd_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               mask_q <= '0;
            end else if (mask_we) begin
               mask_q[byte_sel*BYTE_W +: BYTE_W] <= wr_data;
            end
         end

         always_ff @(posedge clk) begin
            if (rst) begin
               rd_q <= '0;
            end else if (rd_en) begin
               rd_q <= mask_q[byte_sel*BYTE_W +: BYTE_W];
            end
         end

         assign mask    = mask_q;
         assign rd_byte = rd_q;

         // R1: mask clears to all-writable on reset
         a_r1_mask_clear: assert property (@(posedge clk)
            rst |=> (mask_q == '0));
      end else begin : g_none
         logic unused_mask;
         assign unused_mask = ^{clk, rst, mask_we, rd_en, byte_sel, wr_data};
         assign mask    = '0;
         assign rd_byte = '0;
      end
   endgenerate
endmodule

// File: rtl/gsram_array.sv
module gsram_array
   import gsram_pkg::*;
#(
   parameter int MEM_AW = 10
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                we,
   input  logic                re,
   input  logic [MEM_AW-1:0]   word,
   input  logic [BYTE_W-1:0]   wd,
   output logic [BYTE_W-1:0]   rd
);
   localparam int DEPTH = 1 << MEM_AW;

   logic [BYTE_W-1:0] mem [DEPTH];
   logic [BYTE_W-1:0] rd_q;

   always_ff @(posedge clk) begin
      if (we) begin
         mem[word] <= wd;
      end
   end

   // read-first: a same-cycle write is seen on the next read
   always_ff @(posedge clk) begin
      if (rst) begin
         rd_q <= '0;
      end else if (re) begin
         rd_q <= mem[word];
      end
   end

   assign rd = rd_q;
endmodule

// File: rtl/guarded_sram.sv
module guarded_sram
   import gsram_pkg::*;
#(
   parameter int MEM_AW  = 10,
   parameter bit PROTECT = 1'b0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [MEM_AW:0]     addr,
   input  logic                wr_en,
   input  logic [7:0]          wr_data,
   input  logic                rd_en,
   output logic [7:0]          rd_data,
   input  logic                irq_priv
);
   localparam int RGN_W = region_bits(MEM_AW);
   localparam int NRGN  = 1 << RGN_W;
   localparam int NBYTE = NRGN / BYTE_W;
   localparam int SEL_W = $clog2(NBYTE);

   generate
      if (!(MEM_AW == 10 || MEM_AW == 12)) begin : g_bad_size
         $error("guarded_sram: MEM_AW must be 10 or 12");
      end
      if (NRGN % BYTE_W != 0) begin : g_bad_rgn
         $error("guarded_sram: region count must fill whole bytes");
      end
   endgenerate

   logic                win;
   logic [MEM_AW-1:0]   word;
   logic [RGN_W-1:0]    region;
   logic [SEL_W-1:0]    byte_sel;
   logic [NRGN-1:0]     mask;
   logic                ram_we;
   logic                mask_we;
   logic [BYTE_W-1:0]   ram_rd;
   logic [BYTE_W-1:0]   mask_rd;
   logic                src_win_q;

   gsram_decode #(.MEM_AW(MEM_AW), .RGN_W(RGN_W), .SEL_W(SEL_W)) u_dec (
      .addr(addr), .win(win), .word(word), .region(region), .byte_sel(byte_sel)
   );

   gsram_gate #(.PROTECT(PROTECT)) u_gate (
      .wr_en(wr_en), .win(win), .priv(irq_priv), .blocked_bit(mask[region]),
      .ram_we(ram_we), .mask_we(mask_we)
   );

   gsram_mask #(.PROTECT(PROTECT), .NRGN(NRGN), .SEL_W(SEL_W)) u_mask (
      .clk(clk), .rst(rst), .mask_we(mask_we), .rd_en(rd_en),
      .byte_sel(byte_sel), .wr_data(wr_data), .mask(mask), .rd_byte(mask_rd)
   );

   gsram_array #(.MEM_AW(MEM_AW)) u_ram (
      .clk(clk), .rst(rst), .we(ram_we), .re(rd_en & ~win),
      .word(word), .wd(wr_data), .rd(ram_rd)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         src_win_q <= 1'b0;
      end else if (rd_en) begin
         src_win_q <= win;
      end
   end

   assign rd_data = src_win_q ? mask_rd : ram_rd;

   // R7: read data holds while no read is requested
   a_r7_rd_hold: assert property (@(posedge clk) disable iff (rst)
      !rd_en |=> $stable(rd_data));

   // R5: one access never writes both the array and the mask
   a_r5_one_target: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ram_we, mask_we}));

   generate
      if (PROTECT) begin : g_chk
         // R6: without privilege the mask never moves
         a_r6_mask_locked: assert property (@(posedge clk) disable iff (rst)
            !irq_priv |=> $stable(mask));
         // R4: a write into a guarded region never reaches the array
         a_r4_drop_write: assert property (@(posedge clk) disable iff (rst)
            (wr_en && !win && mask[region]) |-> !ram_we);
      end
   endgenerate
endmodule

// File: tb/sim_guarded_sram.sv
`timescale 1ns/1ps
module sim_guarded_sram;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [12:0] ad  = '0;
   logic [2:0]  we  = '0;
   logic [7:0]  wd  = '0;
   logic        re  = 1'b0;
   logic        priv = 1'b0;
   logic [7:0]  rd0, rd1, rd2;
   int          n_cmp = 0;
   int          n_bad = 0;
   bit          done  = 1'b0;

   always #2.5 clk = ~clk;

   guarded_sram #(.MEM_AW(10), .PROTECT(1'b1)) u0 (
      .clk(clk), .rst(rst), .addr(ad[10:0]), .wr_en(we[0]), .wr_data(wd),
      .rd_en(re), .rd_data(rd0), .irq_priv(priv));
   guarded_sram #(.MEM_AW(12), .PROTECT(1'b1)) u1 (
      .clk(clk), .rst(rst), .addr(ad), .wr_en(we[1]), .wr_data(wd),
      .rd_en(re), .rd_data(rd1), .irq_priv(priv));
   guarded_sram #(.MEM_AW(10), .PROTECT(1'b0)) u2 (
      .clk(clk), .rst(rst), .addr(ad[10:0]), .wr_en(we[2]), .wr_data(wd),
      .rd_en(re), .rd_data(rd2), .irq_priv(priv));

   function automatic logic [7:0] pick(int s);
      return (s == 0) ? rd0 : (s == 1) ? rd1 : rd2;
   endfunction

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wr(int s, logic [12:0] a, logic [7:0] d);
      ad = a; wd = d; we = '0; we[s] = 1'b1;
      @(negedge clk);
      we = '0;
   endtask

   task automatic rdc(int s, logic [12:0] a, logic [7:0] exp, string req);
      ad = a; re = 1'b1;
      @(negedge clk);
      re = 1'b0;
      chk(req, pick(s), exp);
   endtask

   task automatic t_reset;
      chk("R1 rd_data after reset u0", rd0, 8'h00);
      rdc(0, 13'h400, 8'h00, "R1 mask byte0 u0");
      rdc(0, 13'h401, 8'h00, "R1 mask byte1 u0");
      rdc(1, 13'h1003, 8'h00, "R1 mask byte3 u1");
      wr(0, 13'h005, 8'hA5);
      rdc(0, 13'h005, 8'hA5, "R1 region0 writable");
   endtask

   task automatic t_region_1k;
      wr(0, 13'h080, 8'h11); wr(0, 13'h0BF, 8'h22);
      wr(0, 13'h07F, 8'h33); wr(0, 13'h0C0, 8'h44);
      priv = 1'b1; wr(0, 13'h400, 8'h04); priv = 1'b0;
      rdc(0, 13'h400, 8'h04, "R5 mask byte0 readback");
      wr(0, 13'h080, 8'hEE); wr(0, 13'h0BF, 8'hEE);
      wr(0, 13'h07F, 8'hEE); wr(0, 13'h0C0, 8'hEE);
      rdc(0, 13'h080, 8'h11, "R2 R4 region2 low edge kept");
      rdc(0, 13'h0BF, 8'h22, "R2 R4 region2 high edge kept");
      rdc(0, 13'h07F, 8'hEE, "R2 region1 written");
      rdc(0, 13'h0C0, 8'hEE, "R2 region3 written");
   endtask

   task automatic t_priv;
      wr(0, 13'h401, 8'hFF);
      rdc(0, 13'h401, 8'h00, "R6 unprivileged mask write ignored");
      wr(0, 13'h3C1, 8'h55);
      rdc(0, 13'h3C1, 8'h55, "R6 region15 still open");
   endtask

   task automatic t_back2back;
      priv = 1'b1;
      wr(0, 13'h401, 8'h80);      // guard region 15
      wr(0, 13'h3C1, 8'h99);      // very next cycle
      wr(0, 13'h7FD, 8'h00);      // window alias of byte1: reopen
      wr(0, 13'h3C2, 8'h77);      // very next cycle
      priv = 1'b0;
      rdc(0, 13'h3C1, 8'h55, "R8 write after mask set dropped");
      rdc(0, 13'h3C2, 8'h77, "R8 write after mask clear stored");
      rdc(0, 13'h401, 8'h00, "R5 alias address reached byte1");
   endtask

   task automatic t_4k;
      wr(1, 13'h0F80, 8'h12); wr(1, 13'h0F7F, 8'h34);
      priv = 1'b1; wr(1, 13'h1003, 8'h80); priv = 1'b0;
      wr(1, 13'h0F80, 8'hAB); wr(1, 13'h0F7F, 8'hAB);
      rdc(1, 13'h0F80, 8'h12, "R3 region31 guarded");
      rdc(1, 13'h0F7F, 8'hAB, "R3 region30 open");
      rdc(1, 13'h1003, 8'h80, "R3 R5 mask byte3 readback");
   endtask

   task automatic t_noprot;
      priv = 1'b1; wr(2, 13'h400, 8'hFF); priv = 1'b0;
      wr(2, 13'h010, 8'h5A);
      rdc(2, 13'h010, 8'h5A, "R9 write stored without protection");
      rdc(2, 13'h400, 8'h00, "R9 mask window reads zero");
   endtask

   task automatic t_hold;
      rdc(0, 13'h080, 8'h11, "R7 read of guarded region");
      for (int i = 0; i < 3; i++) begin
         ad = 13'h07F + 13'(i);
         @(negedge clk);
         chk("R7 rd_data held", rd0, 8'h11);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset;
      t_region_1k;
      t_priv;
      t_back2back;
      t_4k;
      t_noprot;
      t_hold;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule